// File: doc/BRIEF.md
# Protection Entry Permission Checker

This block decides the outcome of one memory-protection entry for one access. It takes the entry's 8-bit configuration byte, a match flag from an address comparator outside the block, the kind of access (instruction fetch, load, or store/atomic), and whether the hart is running in machine mode. From these inputs it produces two flags. The first says whether the entry covers the access. The second says whether the access must take an access fault.

The block is purely combinational and holds no state. A protection unit places one copy beside each entry's address comparator. It then picks the lowest-numbered entry whose hit flag is set and uses that entry's fault flag. The comparator, the range arithmetic and the arbitration across entries all sit outside this block.

The parameter `GRANULARITY` sets the protection grain as a power of two. When it is 2 or larger, the naturally aligned four-byte mode cannot occur. In that case the block treats that mode as a disabled entry.

Top module: `pmp_entry_chk`

## Requirements
- R1: When the match-mode field (config bits 4:3) is 0, `hit_o` and `fault_o` are both 0, whatever `match_i` says.
- R2: For mode 1 (top of range), mode 3 (power-of-two region) and, when GRANULARITY < 2, mode 2 (four-byte region), `hit_o` equals `match_i`. With `match_i` = 0, `fault_o` is 0.
- R3: On an enforced hit with access code 0 (fetch), `fault_o` is 1 exactly when the execute bit (config bit 2) is 0.
- R4: On an enforced hit with access code 1 (load), `fault_o` is 1 exactly when the read bit (config bit 0) is 0.
- R5: On an enforced hit with access code 2 (store or atomic), `fault_o` is 1 exactly when the write bit (config bit 1) is 0.
- R6: On an enforced hit with access code 3, `fault_o` is 1 whatever the permission bits are.
- R7: In machine mode (`priv_m_i` = 1) with the lock bit (config bit 7) at 0, a hit never faults.
- R8: In machine mode with the lock bit at 1, the entry is enforced and R3 to R6 apply.
- R9: Below machine mode (`priv_m_i` = 0), the entry is enforced whatever the lock bit is.
- R10: When GRANULARITY >= 2, mode 2 behaves like mode 0: no hit and no fault.
- R11: `fault_o` is never 1 while `hit_o` is 0. Config bits 6:5 have no effect on either output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cfg_i | input | 8 | Entry configuration byte: lock in bit 7, reserved in bits 6:5, mode in bits 4:3, execute/write/read in bits 2/1/0 |
| match_i | input | 1 | Address comparator reports that the access falls inside the entry |
| priv_m_i | input | 1 | 1 when the access is made in machine mode |
| acc_i | input | 2 | Access kind: 0 fetch, 1 load, 2 store/atomic, 3 invalid |
| hit_o | output | 1 | The entry is enabled and the address matched |
| fault_o | output | 1 | The entry hit, is enforced, and the needed permission is missing |

## Verification
The assertions assume that every input is a settled 0/1 value whenever they are evaluated. They also assume that `match_i` is already the result for the mode in the configuration byte, so they never check the address arithmetic. The stimulus holds each input set steady for a full clock period and checks the outputs half a period later, so every value observed is settled. The access code 3 and the reserved configuration bits are applied on purpose, because the block must behave in a defined way for those inputs.

// File: rtl/pmp_chk_pkg.sv
package pmp_chk_pkg;
  localparam int unsigned CFG_W = 8;
  localparam int unsigned ACC_W = 2;
  localparam int unsigned MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    MODE_OFF   = 2'd0,
    MODE_TOR   = 2'd1,
    MODE_NA4   = 2'd2,
    MODE_NAPOT = 2'd3
  } match_mode_e;

  localparam logic [ACC_W-1:0] ACC_FETCH = 2'd0;
  localparam logic [ACC_W-1:0] ACC_LOAD  = 2'd1;
  localparam logic [ACC_W-1:0] ACC_STORE = 2'd2;

  typedef struct packed {
    logic        lock;
    logic [1:0]  rsvd;
    match_mode_e mode;
    logic        x;
    logic        w;
    logic        r;
  } entry_cfg_t;
endpackage

// File: rtl/pmp_mode_decode.sv
module pmp_mode_decode
  import pmp_chk_pkg::*;
#(
  parameter int unsigned GRANULARITY = 0
) (
  input  match_mode_e mode_i,
  output logic        enabled_o
);
  generate
    if (GRANULARITY < 2) begin : g_na4_ok
      assign enabled_o = (mode_i != MODE_OFF);
    end else begin : g_na4_off
      // four-byte mode cannot exist at coarse grain: treat as disabled
      assign enabled_o = (mode_i == MODE_TOR) || (mode_i == MODE_NAPOT);
    end
  endgenerate
endmodule

// File: rtl/pmp_enforce.sv
module pmp_enforce (
  input  logic lock_i,
  input  logic priv_m_i,
  output logic enforced_o
);
  assign enforced_o = lock_i || !priv_m_i;
endmodule

// File: rtl/pmp_perm_select.sv
module pmp_perm_select
  import pmp_chk_pkg::*;
(
  input  logic [ACC_W-1:0] acc_i,
  input  logic             x_i,
  input  logic             w_i,
  input  logic             r_i,
  output logic             allowed_o
);
  always_comb begin
    unique case (acc_i)
      ACC_FETCH: allowed_o = x_i;
      ACC_LOAD:  allowed_o = r_i;
      ACC_STORE: allowed_o = w_i;
      default:   allowed_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/pmp_entry_chk.sv
module pmp_entry_chk
  import pmp_chk_pkg::*;
#(
  parameter int unsigned GRANULARITY = 0
) (
  input  logic [CFG_W-1:0] cfg_i,
  input  logic             match_i,
  input  logic             priv_m_i,
  input  logic [ACC_W-1:0] acc_i,
  output logic             hit_o,
  output logic             fault_o
);
  entry_cfg_t cfg;
  logic       enabled;
  logic       enforced;
  logic       allowed;

  assign cfg = entry_cfg_t'(cfg_i);

  pmp_mode_decode #(.GRANULARITY(GRANULARITY)) u_mode (
    .mode_i    (cfg.mode),
    .enabled_o (enabled)
  );

  pmp_enforce u_enf (
    .lock_i     (cfg.lock),
    .priv_m_i   (priv_m_i),
    .enforced_o (enforced)
  );

  pmp_perm_select u_perm (
    .acc_i     (acc_i),
    .x_i       (cfg.x),
    .w_i       (cfg.w),
    .r_i       (cfg.r),
    .allowed_o (allowed)
  );

  assign hit_o   = enabled && match_i;
  assign fault_o = hit_o && enforced && !allowed;
endmodule

// File: rtl/pmp_entry_chk_sva.sv
module pmp_entry_chk_sva
  import pmp_chk_pkg::*;
#(
  parameter int unsigned GRANULARITY = 0
) (
  input logic [CFG_W-1:0] cfg_i,
  input logic             match_i,
  input logic             priv_m_i,
  input logic [ACC_W-1:0] acc_i,
  input logic             hit_o,
  input logic             fault_o
);
  always_comb begin
    AST_FAULT_NEEDS_HIT: assert (!fault_o || hit_o) else $error("fault without hit"); // R11
    AST_OFF_NO_HIT: assert (cfg_i[4:3] != 2'd0 || (!hit_o && !fault_o)) else $error("off entry hit"); // R1
    AST_NO_MATCH_NO_HIT: assert (match_i || !hit_o) else $error("hit without match"); // R2
    AST_M_UNLOCKED_SAFE: assert (!(priv_m_i && !cfg_i[7]) || !fault_o) else $error("unlocked M fault"); // R7
    AST_BAD_ACC_FAULTS: assert (!(hit_o && acc_i == 2'd3 && (cfg_i[7] || !priv_m_i)) || fault_o) else $error("bad access allowed"); // R6
    AST_COARSE_NO_NA4: assert (GRANULARITY < 2 || cfg_i[4:3] != 2'd2 || !hit_o) else $error("NA4 hit at coarse grain"); // R10
  end
endmodule

bind pmp_entry_chk pmp_entry_chk_sva #(.GRANULARITY(GRANULARITY)) u_sva (
  .cfg_i    (cfg_i),
  .match_i  (match_i),
  .priv_m_i (priv_m_i),
  .acc_i    (acc_i),
  .hit_o    (hit_o),
  .fault_o  (fault_o)
);

// File: tb/pmp_entry_chk_bench.sv
module pmp_entry_chk_bench;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk = ~clk;

  logic [7:0] cfg;
  logic       match, priv_m;
  logic [1:0] acc;
  logic       hit, fault, hit_c, fault_c;
  int checks = 0;
  int failures = 0;
  bit done = 0;

  pmp_entry_chk u_pmp_entry_chk (
    .cfg_i(cfg), .match_i(match), .priv_m_i(priv_m), .acc_i(acc),
    .hit_o(hit), .fault_o(fault)
  );

  pmp_entry_chk #(.GRANULARITY(2)) u_coarse (
    .cfg_i(cfg), .match_i(match), .priv_m_i(priv_m), .acc_i(acc),
    .hit_o(hit_c), .fault_o(fault_c)
  );

  typedef struct packed {
    logic [7:0] cfg;
    logic       match;
    logic       priv_m;
    logic [1:0] acc;
    logic       hit;
    logic       fault;
    logic [7:0] req;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{8'h07, 1'b1, 1'b0, 2'd1, 1'b0, 1'b0, 8'd1},  // R1 off, all perms
    '{8'h00, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 8'd1},  // R1
    '{8'h08, 1'b0, 1'b0, 2'd1, 1'b0, 1'b0, 8'd2},  // R2 no match
    '{8'h08, 1'b1, 1'b0, 2'd1, 1'b1, 1'b1, 8'd4},  // R4 load, R clear
    '{8'h09, 1'b1, 1'b0, 2'd1, 1'b1, 1'b0, 8'd4},  // R4 load, R set
    '{8'h0C, 1'b1, 1'b0, 2'd0, 1'b1, 1'b0, 8'd3},  // R3 fetch, X set
    '{8'h0B, 1'b1, 1'b0, 2'd0, 1'b1, 1'b1, 8'd3},  // R3 fetch, X clear
    '{8'h1B, 1'b1, 1'b0, 2'd2, 1'b1, 1'b0, 8'd5},  // R5 store, W set
    '{8'h1D, 1'b1, 1'b0, 2'd2, 1'b1, 1'b1, 8'd5},  // R5 store, W clear
    '{8'h17, 1'b1, 1'b0, 2'd3, 1'b1, 1'b1, 8'd6},  // R6 invalid access
    '{8'h17, 1'b1, 1'b0, 2'd1, 1'b1, 1'b0, 8'd2},  // R2 NA4 enabled at fine grain
    '{8'h08, 1'b1, 1'b1, 2'd1, 1'b1, 1'b0, 8'd7},  // R7 M, unlocked
    '{8'h08, 1'b1, 1'b1, 2'd3, 1'b1, 1'b0, 8'd7},  // R7 M, unlocked, bad acc
    '{8'h88, 1'b1, 1'b1, 2'd1, 1'b1, 1'b1, 8'd8},  // R8 M, locked
    '{8'h8F, 1'b1, 1'b1, 2'd0, 1'b1, 1'b0, 8'd8},  // R8 M, locked, X set
    '{8'h88, 1'b1, 1'b0, 2'd0, 1'b1, 1'b1, 8'd9},  // R9 user, locked
    '{8'h68, 1'b1, 1'b0, 2'd1, 1'b1, 1'b1, 8'd11}, // R11 reserved bits set
    '{8'h6F, 1'b1, 1'b0, 2'd1, 1'b1, 1'b0, 8'd11}, // R11
    '{8'h9F, 1'b0, 1'b1, 2'd0, 1'b0, 1'b0, 8'd2}   // R2 locked, no match
  };

  task automatic check(input logic act_h, input logic act_f,
                       input logic exp_h, input logic exp_f, input int req);
    checks++;
    if (act_h !== exp_h || act_f !== exp_f) begin
      failures++;
      $display("FAIL R%0d: hit/fault actual=%b%b expected=%b%b", req, act_h, act_f, exp_h, exp_f);
    end
  endtask

  task automatic apply(input logic [7:0] c, input logic m, input logic p, input logic [1:0] a);
    @(posedge clk);
    cfg = c; match = m; priv_m = p; acc = a;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    cfg = 8'h00; match = 1'b0; priv_m = 1'b0; acc = 2'd0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(hit, fault, 1'b0, 1'b0, 1);  // R1 idle inputs after reset
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].cfg, VECS[i].match, VECS[i].priv_m, VECS[i].acc);
      check(hit, fault, VECS[i].hit, VECS[i].fault, int'(VECS[i].req));
    end

    // R10 coarse grain: NA4 acts as off
    apply(8'h10, 1'b1, 1'b0, 2'd1);
    check(hit_c, fault_c, 1'b0, 1'b0, 10);
    apply(8'h97, 1'b1, 1'b1, 2'd3);
    check(hit_c, fault_c, 1'b0, 1'b0, 10);
    apply(8'h18, 1'b1, 1'b0, 2'd1);
    check(hit_c, fault_c, 1'b1, 1'b1, 10);  // R10 NAPOT still enabled
    apply(8'h09, 1'b1, 1'b0, 2'd1);
    check(hit_c, fault_c, 1'b1, 1'b0, 10);

    // R1 off with lock and every access kind
    for (int a = 0; a < 4; a++) begin
      apply(8'h80, 1'b1, 1'b1, 2'(a));
      check(hit, fault, 1'b0, 1'b0, 1);
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule